// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a shadow SRAM array is copied into its nonvolatile backing cells (a store) and when the backing cells are copied back into the SRAM (a recall). Four sources can start an operation. A supply-fail flag and an active-low hardware store pin start a store only if the SRAM was written since the last completed store or recall. A software request always starts a store. A recall request always starts a recall. The copy is parallel and takes a fixed number of cycles, so the sequencer times it with an internal counter and marks its first cycle with a one-cycle start pulse.

A low level on the hardware pin does not start a store at once. It opens a grace window of a fixed length. Reads go on during the window, and a write cycle that was already active when the window opened may run to its end. A write that starts inside the window is refused. When the window closes, the sequencer stores if the array is dirty and otherwise skips the store. In both cases it then holds the array locked until the pin is seen high again. While a copy runs, or while the array is held, all accesses are inhibited. The open-drain-style busy output is pulled low for the whole duration of a store.

Top module: `nvs_seq`

## Requirements
- R1: After reset the sequencer is idle: busy_n is 1, and acc_inh, wr_inh, store_go and recall_go are 0.
- R2: acc_inh is 1 in every cycle of a store, of a recall, and of the hold phase. It is 0 in idle and in the grace window. wr_inh is 1 whenever acc_inh is 1.
- R3: When pwr_fail is 1 in idle and the array is dirty, a store starts on the next cycle without a grace window. When the array is clean, pwr_fail does nothing.
- R4: A software request (sw_req pulse) starts a store even when the array is clean.
- R5: hw_store_n sampled low in idle opens a grace window of exactly T_GRACE cycles. A write cycle accepted up to and including the last window cycle counts toward the dirty decision.
- R6: In the grace window, a write cycle (wr_act high) that was active on the cycle the window opened is not inhibited until wr_act first drops. After that, wr_inh stays 1 for the rest of the window.
- R7: During a store, busy_n is 0 for exactly T_STORE cycles. store_go is 1 only in the first of those cycles.
- R8: After a store completes, the sequencer stays in the hold phase with accesses inhibited until hw_store_n is sampled high. It then returns to idle on the following cycle.
- R9: A write cycle is accepted (the array becomes dirty) when wr_act is 1 and wr_inh is 0. A completed store or recall makes the array clean.
- R10: In idle, triggers are ranked: a valid supply-fail store first, then the hardware pin, then the software request, then the recall request. sw_req and recall_req pulses are held pending until they are served.
- R11: A recall runs whether the array is dirty or clean. It lasts T_RECALL cycles, recall_go is 1 only in its first cycle, busy_n stays 1 (default variant), and the sequencer then returns to idle.
- R12: When the grace window ends with a clean array, no store runs. busy_n stays 1 and the sequencer enters the hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_store_n | input | 1 | Hardware store pin, active low |
| sw_req | input | 1 | Software store request, one-cycle pulse |
| pwr_fail | input | 1 | Supply below switch threshold |
| recall_req | input | 1 | Power-up/recall request, one-cycle pulse |
| wr_act | input | 1 | SRAM write cycle active |
| busy_n | output | 1 | Busy, driven low while a store runs |
| acc_inh | output | 1 | Inhibit SRAM reads and writes |
| wr_inh | output | 1 | Inhibit SRAM writes |
| store_go | output | 1 | Start pulse to the copy engine, SRAM to nonvolatile |
| recall_go | output | 1 | Start pulse to the copy engine, nonvolatile to SRAM |

## Verification
The bench targets several corner cases. It checks that a clean array makes supply-fail and pin triggers do nothing; a design that ignored the dirty flag would wear the cells with stores that are not needed. It checks the grace window with a write that runs across the window's opening and a second write that starts inside it; a design that got this wrong would cut off the legal write or let the new write land after the decision. It checks simultaneous triggers and requests that arrive while an operation is running; bad ranking or lost pending bits would show up as a missing or reordered store. It checks that a recall clears the dirty flag, so that a later supply fail with no new write does not store stale state.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_GRACE  = 3'd1,
      PH_STORE  = 3'd2,
      PH_RECALL = 3'd3,
      PH_HOLD   = 3'd4
   } phase_t;

   typedef enum logic [2:0] {
      TG_NONE = 3'd0,
      TG_PF   = 3'd1,
      TG_HW   = 3'd2,
      TG_SW   = 3'd3,
      TG_RC   = 3'd4
   } trig_t;

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R5
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));

   // R7
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/nvs_wgate.sv
module nvs_wgate (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_act,
   input  logic wr_inh,
   input  logic grace_enter,
   input  logic clr,
   output logic carry,
   output logic dirty_eff
);

   logic dirty_q;
   logic wr_ok;

   assign wr_ok     = wr_act & ~wr_inh;
   assign dirty_eff = dirty_q | wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dirty_q <= 1'b0;
         carry   <= 1'b0;
      end else begin
         dirty_q <= clr ? 1'b0 : dirty_eff;
         carry   <= grace_enter ? wr_act : (carry & wr_act);
      end
   end

   // R9
   clean_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !dirty_q);

   // R6
   carry_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!carry && !grace_enter) |=> !carry);

endmodule

// File: rtl/nvs_trig.sv
module nvs_trig
   import nvs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pwr_fail,
   input  logic  hw_store_n,
   input  logic  sw_req,
   input  logic  recall_req,
   input  logic  dirty_eff,
   input  logic  idle,
   output trig_t sel
);

   logic sw_pend, rc_pend;
   logic sw_any, rc_any;

   assign sw_any = sw_pend | sw_req;
   assign rc_any = rc_pend | recall_req;

   always_comb begin
      if (pwr_fail && dirty_eff) sel = TG_PF;
      else if (!hw_store_n)      sel = TG_HW;
      else if (sw_any)           sel = TG_SW;
      else if (rc_any)           sel = TG_RC;
      else                       sel = TG_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_pend <= 1'b0;
         rc_pend <= 1'b0;
      end else begin
         sw_pend <= sw_any & ~(idle && sel == TG_SW);
         rc_pend <= rc_any & ~(idle && sel == TG_RC);
      end
   end

   // R10
   sw_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == TG_SW) |-> (hw_store_n && !(pwr_fail && dirty_eff)));

   // R10
   sw_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && !idle) |=> sw_pend);

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int T_GRACE        = 4,
   parameter int T_STORE        = 6,
   parameter int T_RECALL       = 3,
   parameter bit BUSY_ON_RECALL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_store_n,
   input  logic sw_req,
   input  logic pwr_fail,
   input  logic recall_req,
   input  logic wr_act,
   output logic busy_n,
   output logic acc_inh,
   output logic wr_inh,
   output logic store_go,
   output logic recall_go
);

   localparam int T_MAX = (T_GRACE > T_STORE) ?
                          ((T_GRACE > T_RECALL) ? T_GRACE : T_RECALL) :
                          ((T_STORE > T_RECALL) ? T_STORE : T_RECALL);
   localparam int CW = $clog2(T_MAX + 1);
   localparam logic [CW-1:0] GR_M1 = CW'(T_GRACE - 1);
   localparam logic [CW-1:0] ST_M1 = CW'(T_STORE - 1);
   localparam logic [CW-1:0] RC_M1 = CW'(T_RECALL - 1);

   if (T_GRACE < 1)  begin : g_bad_grace  $error("T_GRACE must be at least 1");  end
   if (T_STORE < 1)  begin : g_bad_store  $error("T_STORE must be at least 1");  end
   if (T_RECALL < 1) begin : g_bad_recall $error("T_RECALL must be at least 1"); end

   phase_t        st, st_nxt;
   trig_t         sel;
   logic          ld, clr, genter, tmr_zero;
   logic [CW-1:0] ldv;
   logic          carry, dirty_eff;
   logic          first_q;

   nvs_trig u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_fail   (pwr_fail),
      .hw_store_n (hw_store_n),
      .sw_req     (sw_req),
      .recall_req (recall_req),
      .dirty_eff  (dirty_eff),
      .idle       (st == PH_IDLE),
      .sel        (sel)
   );

   nvs_wgate u_wgate (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_act      (wr_act),
      .wr_inh      (wr_inh),
      .grace_enter (genter),
      .clr         (clr),
      .carry       (carry),
      .dirty_eff   (dirty_eff)
   );

   nvs_timer #(.W(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ldv),
      .zero     (tmr_zero)
   );

   always_comb begin
      st_nxt = st;
      ld     = 1'b0;
      ldv    = '0;
      clr    = 1'b0;
      genter = 1'b0;
      unique case (st)
         PH_IDLE: begin
            unique case (sel)
               TG_PF, TG_SW: begin st_nxt = PH_STORE;  ld = 1'b1; ldv = ST_M1; end
               TG_HW:        begin st_nxt = PH_GRACE;  ld = 1'b1; ldv = GR_M1; genter = 1'b1; end
               TG_RC:        begin st_nxt = PH_RECALL; ld = 1'b1; ldv = RC_M1; end
               default:      st_nxt = PH_IDLE;
            endcase
         end
         PH_GRACE: begin
            if (tmr_zero) begin
               if (dirty_eff) begin
                  st_nxt = PH_STORE;
                  ld     = 1'b1;
                  ldv    = ST_M1;
               end else begin
                  st_nxt = PH_HOLD;
               end
            end
         end
         PH_STORE: begin
            if (tmr_zero) begin
               st_nxt = PH_HOLD;
               clr    = 1'b1;
            end
         end
         PH_RECALL: begin
            if (tmr_zero) begin
               st_nxt = PH_IDLE;
               clr    = 1'b1;
            end
         end
         PH_HOLD: begin
            if (hw_store_n) st_nxt = PH_IDLE;
         end
         default: st_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= PH_IDLE;
         first_q <= 1'b0;
      end else begin
         st      <= st_nxt;
         first_q <= ld && (st_nxt == PH_STORE || st_nxt == PH_RECALL);
      end
   end

   assign acc_inh   = (st == PH_STORE) || (st == PH_RECALL) || (st == PH_HOLD);
   assign wr_inh    = (st == PH_GRACE) ? ~carry : acc_inh;
   assign store_go  = (st == PH_STORE)  && first_q;
   assign recall_go = (st == PH_RECALL) && first_q;

   if (BUSY_ON_RECALL) begin : g_busy_both
      assign busy_n = !((st == PH_STORE) || (st == PH_RECALL));
   end else begin : g_busy_store
      assign busy_n = !(st == PH_STORE);
   end

   // R2
   inh_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_inh |-> wr_inh);

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_n) |-> (store_go || recall_go));

   // R8
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HOLD && !hw_store_n) |=> acc_inh);

   // R12
   skip_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_GRACE && tmr_zero && !dirty_eff) |=> (st == PH_HOLD && busy_n));

   // R3
   pf_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_IDLE && sel == TG_PF) |=> store_go);

endmodule

// File: tb/sim_nvs_seq.sv
`timescale 1ns/1ps
module sim_nvs_seq;

   localparam int DLY = 4;
   localparam int STC = 6;
   localparam int RCC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hw_store_n = 1'b1, sw_req = 1'b0, pwr_fail = 1'b0, recall_req = 1'b0, wr_act = 1'b0;
   logic busy_n, acc_inh, wr_inh, store_go, recall_go;

   always #2 clk = ~clk;

   nvs_seq #(.T_GRACE(DLY), .T_STORE(STC), .T_RECALL(RCC), .BUSY_ON_RECALL(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .hw_store_n(hw_store_n), .sw_req(sw_req),
      .pwr_fail(pwr_fail), .recall_req(recall_req), .wr_act(wr_act),
      .busy_n(busy_n), .acc_inh(acc_inh), .wr_inh(wr_inh),
      .store_go(store_go), .recall_go(recall_go)
   );

   int n_vec = 0, n_bad = 0;
   int stores = 0, recalls = 0;
   bit done = 1'b0;

   // reference model: 0 idle, 1 window, 2 storing, 3 recalling, 4 held
   int m_ph = 0, m_rem = 0;
   bit m_dirty = 0, m_carry = 0, m_swp = 0, m_rcp = 0;

   function automatic bit exp_wr_inh();
      if (m_ph == 1) return !m_carry;
      return (m_ph >= 2);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit ok, deff, swp, rcp, ended;
         ok    = wr_act && !exp_wr_inh();
         deff  = m_dirty || ok;
         swp   = m_swp || sw_req;
         rcp   = m_rcp || recall_req;
         ended = 0;
         case (m_ph)
            0: begin
               if (pwr_fail && deff)  begin m_ph = 2; m_rem = STC; end
               else if (!hw_store_n)  begin m_ph = 1; m_rem = DLY; m_carry = wr_act; end
               else if (swp)          begin m_ph = 2; m_rem = STC; swp = 0; end
               else if (rcp)          begin m_ph = 3; m_rem = RCC; rcp = 0; end
            end
            1: begin
               m_carry = m_carry && wr_act;
               m_rem--;
               if (m_rem == 0) begin
                  if (deff) begin m_ph = 2; m_rem = STC; end
                  else m_ph = 4;
               end
            end
            2: begin m_rem--; if (m_rem == 0) begin m_ph = 4; ended = 1; end end
            3: begin m_rem--; if (m_rem == 0) begin m_ph = 0; ended = 1; end end
            default: if (hw_store_n) m_ph = 0;
         endcase
         m_dirty = ended ? 1'b0 : deff;
         m_swp = swp;
         m_rcp = rcp;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      chk("R2 acc_inh", acc_inh, (m_ph >= 2));
      chk("R6 wr_inh", wr_inh, exp_wr_inh());
      chk("R7 busy_n", busy_n, (m_ph != 2));
      chk("R7 store_go", store_go, (m_ph == 2 && m_rem == STC));
      chk("R11 recall_go", recall_go, (m_ph == 3 && m_rem == RCC));
      if (store_go) stores++;
      if (recall_go) recalls++;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         finish_run();
      end
   end

   initial begin
      int t;
      run(3);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      step();
      chk("R1 busy_n", busy_n, 1);
      chk("R1 acc_inh", acc_inh, 0);
      chk("R1 wr_inh", wr_inh, 0);

      // R3 supply fail on a clean array: nothing
      pwr_fail = 1'b1; run(5); pwr_fail = 1'b0; run(2);
      chk("R3 clean pf stores", stores, 0);

      // R3 dirty array then supply fail: store without window
      wr_act = 1'b1; step(); wr_act = 1'b0;
      pwr_fail = 1'b1; step(); pwr_fail = 1'b0;
      chk("R3 pf store_go next cycle", store_go, 1);
      run(STC + 4);
      chk("R3 pf store count", stores, 1);
      // R9 store cleaned the array
      pwr_fail = 1'b1; run(5); pwr_fail = 1'b0; run(2);
      chk("R9 no store after clean", stores, 1);

      // R4 software store on a clean array
      sw_req = 1'b1; step(); sw_req = 1'b0;
      run(STC + 4);
      chk("R4 sw store count", stores, 2);

      // R12 pin low with clean array: window, no store, held
      hw_store_n = 1'b0; run(DLY + 6);
      chk("R12 no store", stores, 2);
      chk("R8 held while pin low", acc_inh, 1);
      hw_store_n = 1'b1; run(2);
      chk("R8 released", acc_inh, 0);

      // R5/R6 write across window start, new write refused, exact window length
      wr_act = 1'b1; step();
      hw_store_n = 1'b0; t = 0;
      step(); t++;
      chk("R6 carried write allowed", wr_inh, 0);
      step(); t++;
      wr_act = 1'b0; step(); t++;
      wr_act = 1'b1; step(); t++;
      chk("R6 new write blocked", wr_inh, 1);
      wr_act = 1'b0;
      while (!store_go && t < 50) begin step(); t++; end
      chk("R5 window length", t, DLY + 1);
      run(STC + 4);
      chk("R5 store count", stores, 3);
      chk("R8 held after store", acc_inh, 1);
      hw_store_n = 1'b1; run(3);

      // R11 recall with dirty array, then R9 supply fail does nothing
      wr_act = 1'b1; step(); wr_act = 1'b0;
      recall_req = 1'b1; step(); recall_req = 1'b0;
      chk("R11 recall_go", recall_go, 1);
      chk("R11 busy_n during recall", busy_n, 1);
      run(RCC + 3);
      chk("R11 recall count", recalls, 1);
      pwr_fail = 1'b1; run(4); pwr_fail = 1'b0; run(2);
      chk("R9 recall cleaned", stores, 3);

      // R10 simultaneous pf, pin and sw: pf first, sw kept pending
      wr_act = 1'b1; step(); wr_act = 1'b0;
      pwr_fail = 1'b1; hw_store_n = 1'b0; sw_req = 1'b1; step();
      sw_req = 1'b0; pwr_fail = 1'b0;
      chk("R10 pf wins immediately", store_go, 1);
      run(STC + 6);
      chk("R10 one store while pin low", stores, 4);
      hw_store_n = 1'b1; run(STC + 6);
      chk("R10 pending sw served", stores, 5);

      // R10 sw and recall together: store first then recall
      sw_req = 1'b1; recall_req = 1'b1; step(); sw_req = 1'b0; recall_req = 1'b0;
      chk("R10 sw before recall", store_go, 1);
      run(STC + RCC + 8);
      chk("R10 stores", stores, 6);
      chk("R10 recall after", recalls, 2);

      finish_run();
   end

endmodule